// File: doc/BRIEF.md
# Three-Level H-Bridge PWM Modulator

This block turns a signed digital drive command into the two half-bridge switching levels of a full H-bridge. It uses three-level modulation, in which both legs switch together. With no command, the two legs rise and fall in the same cycles, so the voltage across the load is zero for nearly the whole period. A non-zero command stretches one leg's pulse and shrinks the other's by the same amount. The load then sees short differential pulses whose polarity follows the sign of the command. Each leg only ever switches between ground and the supply rail.

Both legs are compared against one triangular carrier, and each pulse is centred in the middle of the carrier period. The carrier is derived from the system clock by a counter, and a select input picks one of two half-period lengths. At 160 MHz the defaults give 400 kHz when the select is low and 500 kHz when it is high. The command and the select are captured only at the end of a carrier period. A half-finished pulse is therefore never cut short or lengthened. When the enable input is low or the fault input is high, the output stage is released to high impedance without delay. The carrier then starts a fresh period when the block is released.

Top module: `bd_pwm_modulator`

## Requirements
- R1: While `enable` is 0 or `fault` is 1, `out_hiz` is 1 and both `drive_pos` and `drive_neg` are 0 in the same cycle, with no clock edge in between.
- R2: With a zero command, each leg is high for exactly half of every carrier period, and the two legs are identical in every cycle.
- R3: With command c > 0, the positive leg is high for 2*T+ cycles per period and the negative leg for 2*T- cycles. Here T± = H/2 ± floor(c*H / 2^CMD_W), where H is the half-period in clocks and the command is two's complement. The result is that the positive leg is above 50 % duty and the negative leg below it, and the negative leg's pulse lies inside the positive leg's pulse.
- R4: With command c < 0, the same formula applies. The negative leg is then above 50 % duty and the positive leg below it.
- R5: `freq_fast` = 0 selects a period of 2*HALF_SLOW clocks, and `freq_fast` = 1 selects 2*HALF_FAST clocks. Out of reset the slow setting is in force.
- R6: Each threshold T± is clamped to the range [H - floor(H*MAX_PCT/100), floor(H*MAX_PCT/100)]. With MAX_PCT below 96, no leg ever reaches 96 % duty.
- R7: Changes to `cmd` or `freq_fast` made part-way through a period have no effect on that period. They apply from the next period on, since the block samples them only on the last cycle of a period.
- R8: Each pulse is centred in its period. Both legs are low in the first and the last cycle of every period.
- R9: The first cycle after `out_hiz` falls is the first cycle of a new carrier period. It uses the command and select present on the clock edge just before the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Output stage enable; 0 forces high impedance |
| fault | input | 1 | Protection fault; 1 forces high impedance |
| freq_fast | input | 1 | Switching frequency select: 0 slow, 1 fast |
| cmd | input | CMD_W | Signed drive command, full scale ±2^(CMD_W-1) |
| drive_pos | output | 1 | Positive half-bridge level (1 = supply rail) |
| drive_neg | output | 1 | Negative half-bridge level (1 = supply rail) |
| out_hiz | output | 1 | Both half-bridges to high impedance |

## Verification
The bench builds the block with HALF_SLOW = 20, HALF_FAST = 16, CMD_W = 8 and MAX_PCT = 95. This keeps the 4:5 ratio of the two switching frequencies while shrinking a period to 40 or 32 clocks. With these values, whole periods can be counted cycle by cycle, and the full command range (-128 to 127) reaches both clamp limits. The small half-periods also make rounding of the floored scaling visible in the high-cycle counts. A change of frequency in mid-period shows up as a change in window length at the very next boundary.

// File: rtl/bd_pwm_modulator.sv
module bd_pwm_modulator #(
  parameter int HALF_SLOW = 200,
  parameter int HALF_FAST = 160,
  parameter int CMD_W     = 12,
  parameter int MAX_PCT   = 95
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    fault,
  input  logic                    freq_fast,
  input  logic signed [CMD_W-1:0] cmd,
  output logic                    drive_pos,
  output logic                    drive_neg,
  output logic                    out_hiz
);

  localparam int HMAX    = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int HW      = $clog2(2 * HMAX + 1);
  localparam int PW      = CMD_W + HW + 2;
  localparam int HI_S    = HALF_SLOW * MAX_PCT / 100;
  localparam int HI_F    = HALF_FAST * MAX_PCT / 100;

  logic          fast_q;
  logic [HW-1:0] pcnt, thr_p, thr_n;
  logic [HW-1:0] half_q, last_q, carrier, hi_q, lo_q;

  wire blocked = !enable || fault;
  assign out_hiz = blocked;

  assign half_q  = fast_q ? HW'(HALF_FAST) : HW'(HALF_SLOW);
  assign last_q  = fast_q ? HW'(2 * HALF_FAST - 1) : HW'(2 * HALF_SLOW - 1);
  assign hi_q    = fast_q ? HW'(HI_F) : HW'(HI_S);
  assign lo_q    = fast_q ? HW'(HALF_FAST - HI_F) : HW'(HALF_SLOW - HI_S);
  assign carrier = (pcnt < half_q) ? (half_q - 1'b1 - pcnt) : (pcnt - half_q);

  assign drive_pos = !blocked && (carrier < thr_p);
  assign drive_neg = !blocked && (carrier < thr_n);

  // next-period thresholds, computed from the live inputs
  logic [HW-1:0]        new_half;
  logic signed [PW-1:0] cmd_x, half_x, prod, delta, mid, raw_p, raw_n, hi_x, lo_x;

  assign new_half = freq_fast ? HW'(HALF_FAST) : HW'(HALF_SLOW);
  assign cmd_x    = {{(PW-CMD_W){cmd[CMD_W-1]}}, cmd};
  assign half_x   = {{(PW-HW){1'b0}}, new_half};
  assign hi_x     = freq_fast ? PW'(HI_F) : PW'(HI_S);
  assign lo_x     = freq_fast ? PW'(HALF_FAST - HI_F) : PW'(HALF_SLOW - HI_S);
  assign prod     = cmd_x * half_x;
  assign delta    = prod >>> CMD_W;
  assign mid      = half_x >>> 1;
  assign raw_p    = mid + delta;
  assign raw_n    = mid - delta;

  function automatic logic [HW-1:0] clip(input logic signed [PW-1:0] v,
                                         input logic signed [PW-1:0] lo,
                                         input logic signed [PW-1:0] hi);
    logic signed [PW-1:0] r;
    r = (v > hi) ? hi : ((v < lo) ? lo : v);
    return r[HW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt   <= '0;
      fast_q <= 1'b0;
      thr_p  <= HW'(HALF_SLOW / 2);
      thr_n  <= HW'(HALF_SLOW / 2);
    end else if (blocked || pcnt == last_q) begin
      pcnt   <= '0;
      fast_q <= freq_fast;
      thr_p  <= clip(raw_p, lo_x, hi_x);
      thr_n  <= clip(raw_n, lo_x, hi_x);
    end else begin
      pcnt   <= pcnt + 1'b1;
    end
  end

  // R7
  hold_mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blocked && pcnt != last_q) |=> ($stable(thr_p) && $stable(thr_n) && $stable(fast_q)));

  // R9
  restart_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_hiz) |-> (pcnt == '0));

  // R6
  thr_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_p <= hi_q) && (thr_p >= lo_q) && (thr_n <= hi_q) && (thr_n >= lo_q));

  // R8
  edge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_hiz && (pcnt == '0 || pcnt == last_q)) |-> (!drive_pos && !drive_neg));

  // R3
  pulse_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_hiz && thr_p >= thr_n && drive_neg) |-> drive_pos);

  // R5
  period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blocked && pcnt == last_q) |=> (pcnt == '0));

endmodule

// File: tb/bd_pwm_modulator_bench.sv
module bd_pwm_modulator_bench;
  localparam int HS = 20, HF = 16, CW = 8, MP = 95;

  logic clk = 0, rst_n = 0, enable = 0, fault = 0, freq_fast = 0;
  logic signed [CW-1:0] cmd = '0;
  logic drive_pos, drive_neg, out_hiz;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  bd_pwm_modulator #(.HALF_SLOW(HS), .HALF_FAST(HF), .CMD_W(CW), .MAX_PCT(MP)) u_bd_pwm_modulator (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fault(fault), .freq_fast(freq_fast),
    .cmd(cmd), .drive_pos(drive_pos), .drive_neg(drive_neg), .out_hiz(out_hiz));

  function automatic int exp_thr(input int c, input int h, input bit pos);
    int d, r, hi, lo;
    d  = (c * h) >>> CW;
    r  = h / 2 + (pos ? d : -d);
    hi = h * MP / 100;
    lo = h - hi;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int hp, hn;
  bit inph, edges_ok, nest_ok;

  task automatic measure(input int h, input int chg_at, input int ncmd, input bit nfast);
    hp = 0; hn = 0; inph = 1; edges_ok = 1; nest_ok = 1;
    for (int i = 0; i < 2 * h; i++) begin
      if (drive_pos) hp++;
      if (drive_neg) hn++;
      if (drive_pos != drive_neg) inph = 0;
      if ((i == 0 || i == 2 * h - 1) && (drive_pos || drive_neg)) edges_ok = 0;
      if (i == chg_at) begin cmd = CW'(ncmd); freq_fast = nfast; end
      @(negedge clk);
    end
  endtask

  task automatic check_period(input int c, input int h, input string tag);
    int tp, tn;
    tp = exp_thr(c, h, 1);
    tn = exp_thr(c, h, 0);
    chk(hp == 2 * tp, {tag, " pos high count"}, hp, 2 * tp);
    chk(hn == 2 * tn, {tag, " neg high count"}, hn, 2 * tn);
    chk(edges_ok, "R8 period edges low", edges_ok, 1);
    chk(hp * 100 < 96 * 2 * h && hn * 100 < 96 * 2 * h, "R6 duty below 96%", (hp > hn) ? hp : hn, 2 * h);
  endtask

  task automatic start(input int c, input bit f);
    @(negedge clk);
    enable = 0; cmd = CW'(c); freq_fast = f;
    @(negedge clk);
    enable = 1;
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    chk(!drive_pos && !drive_neg && out_hiz, "R1 reset state", {drive_pos, drive_neg, out_hiz}, 1);
    rst_n = 1;
    @(negedge clk);

    // R2 zero command, slow (reset default select)
    start(0, 0);
    measure(HS, -1, 0, 0);
    chk(hp == HS && hn == HS, "R2 zero cmd half duty", hp, HS);
    chk(inph, "R2 legs in phase", inph, 1);
    chk(edges_ok, "R8 zero cmd edges low", edges_ok, 1);

    // R5 fast select, zero command
    start(0, 1);
    measure(HF, -1, 0, 1);
    chk(hp == HF && inph && edges_ok, "R5 fast period half duty", hp, HF);

    // R3 positive
    start(64, 0);
    measure(HS, -1, 0, 0);
    check_period(64, HS, "R3");
    chk(hp > HS && hn < HS, "R3 pos above 50", hp, HS);

    // R4 negative
    start(-64, 1);
    measure(HF, -1, 0, 1);
    check_period(-64, HF, "R4");
    chk(hn > HF && hp < HF, "R4 neg above 50", hn, HF);

    // R6 clamp at both extremes
    start(127, 0);
    measure(HS, -1, 0, 0);
    chk(hp == 2 * (HS * MP / 100), "R6 clamp high", hp, 2 * (HS * MP / 100));
    start(-128, 1);
    measure(HF, -1, 0, 1);
    chk(hn == 2 * (HF * MP / 100), "R6 clamp high neg", hn, 2 * (HF * MP / 100));
    chk(hp == 2 * (HF - HF * MP / 100), "R6 clamp low", hp, 2 * (HF - HF * MP / 100));

    // R7 mid-period change: period keeps old values, next uses new
    start(40, 0);
    measure(HS, HS - 3, -90, 1);
    check_period(40, HS, "R7 old period");
    measure(HF, -1, 0, 1);
    check_period(-90, HF, "R7 new period");
    measure(HF, -1, 0, 1);
    check_period(-90, HF, "R5 fast repeats");

    // R1 fault and disable act immediately; R9 restart on release
    cmd = 8'sd100; freq_fast = 0;
    repeat (5) @(negedge clk);
    fault = 1;
    #1;
    chk(out_hiz && !drive_pos && !drive_neg, "R1 fault hiz", {out_hiz, drive_pos, drive_neg}, 4);
    @(negedge clk);
    fault = 0;
    #1;
    measure(HS, -1, 0, 0);
    check_period(100, HS, "R9 restart after fault");
    repeat (7) @(negedge clk);
    enable = 0;
    #1;
    chk(out_hiz && !drive_pos && !drive_neg, "R1 disable hiz", {out_hiz, drive_pos, drive_neg}, 4);
    cmd = -8'sd30; freq_fast = 1;
    @(negedge clk);
    enable = 1;
    #1;
    measure(HF, -1, 0, 1);
    check_period(-30, HF, "R9 restart after disable");

    // random trials
    for (int t = 0; t < 40; t++) begin
      int c;
      bit f;
      c = int'($urandom_range(255)) - 128;
      f = $urandom_range(1);
      start(c, f);
      measure(f ? HF : HS, -1, 0, f);
      check_period(c, f ? HF : HS, (c > 0) ? "R3 random" : ((c < 0) ? "R4 random" : "R2 random"));
      if (c == 0) chk(inph, "R2 random in phase", inph, 1);
    end

    enable = 0;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule